// File: doc/BRIEF.md
# Conditional Execute and Instruction-Class Decoder

This block is a single registered decode stage for a 32-bit load/store instruction word. When an input word is marked valid, the block does two things. It tests the word's 4-bit condition field against the current negative, zero, carry and overflow flags to decide whether the instruction should execute. It also sorts the word into one of sixteen instruction classes. Both results, together with a branch-with-link indication, are registered and appear one cycle later under a valid strobe.

Later pipeline stages use the class code to steer operand fetch and execution, and they use the execute-enable bit to squash instructions whose condition fails. Class decoding tests fixed bit patterns in bits 27:20, 11:4 and 19:8 in a set priority order, so the narrow patterns win over the broad data-processing class.

Top module: `insn_gate_decode`

## Requirements
- R1: While reset is asserted and after its release, until the first valid word, out_valid, out_exec and out_link are 0 and out_class is 0.
- R2: out_valid in each cycle equals in_valid of the previous cycle.
- R3: With in_flags = {N,Z,C,V}, condition field in_word[31:28] codes 0..7 execute respectively when Z=1, Z=0, C=1, C=0, N=1, N=0, V=1, V=0.
- R4: Code 8 executes when C=1 and Z=0; 9 when C=0 or Z=1; 10 when N=V; 11 when N!=V; 12 when N=V and Z=0; 13 when Z=1 or N!=V.
- R5: Code 14 always executes; code 15 never executes.
- R6: A word with bits 27:25=011 and bit 4=1 is class 15 (undefined); any other word with bits 27:26=01 is class 5 (single transfer).
- R7: Bits 27:22 zero and bits 7:4=1001 give class 1 (multiply); bits 27:23=00001 and bits 7:4=1001 give class 2 (long multiply); bits 27:23=00010, bits 21:20=00 and bits 11:4=0x09 give class 3 (swap).
- R8: Any remaining word with bits 27:25=000, bit 7=1 and bit 4=1 is class 4 (halfword transfer).
- R9: Bits 27:4 equal to 0x12FFF1 give class 8 (branch-exchange), taking priority over the status-write pattern.
- R10: Bits 27:25=100 give class 6 (block transfer); 101 give class 7 (branch), with out_link equal to bit 24 (out_link is 0 for every other class); 110 give class 12 (coprocessor transfer); bits 27:24=1111 give class 11 (software interrupt); bits 27:24=1110 give class 14 when bit 4=1 and class 13 when bit 4=0.
- R11: Bits 27:23=00010, bits 21:20=00 and bits 11:4 zero give class 9 (status read). Bits 27:26=00, bits 24:23=10 and bits 21:20=10 give class 10 (status write), unless an earlier pattern matches.
- R12: Any remaining word with bits 27:26=00 is class 0 (data processing).
- R13: In a cycle after in_valid was 0, out_exec, out_class and out_link keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_word | input | 32 | Instruction word |
| in_flags | input | 4 | Current flags {N,Z,C,V} |
| out_valid | output | 1 | Registered valid strobe |
| out_exec | output | 1 | Condition passed |
| out_class | output | 4 | Instruction class code |
| out_link | output | 1 | Branch with link |

## Verification
Every result, including the valid strobe, the execute bit, the class and the link bit, is due exactly one rising edge after the word and flags are presented. The bench drives inputs on the falling edge and, on the next falling edge, compares the outputs against a reference that it computed from the inputs driven in the previous step. An idle cycle leaves the expected class, execute bit and link bit unchanged, so the hold behaviour is compared in the same per-cycle step.

// File: rtl/insn_gate_decode.sv
module insn_gate_decode (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  input  logic [3:0]  in_flags,
  output logic        out_valid,
  output logic        out_exec,
  output logic [3:0]  out_class,
  output logic        out_link
);

  localparam logic [3:0] C_DP    = 4'd0;
  localparam logic [3:0] C_MUL   = 4'd1;
  localparam logic [3:0] C_MULL  = 4'd2;
  localparam logic [3:0] C_SWAP  = 4'd3;
  localparam logic [3:0] C_HALF  = 4'd4;
  localparam logic [3:0] C_SDT   = 4'd5;
  localparam logic [3:0] C_BDT   = 4'd6;
  localparam logic [3:0] C_BR    = 4'd7;
  localparam logic [3:0] C_BX    = 4'd8;
  localparam logic [3:0] C_MRS   = 4'd9;
  localparam logic [3:0] C_MSR   = 4'd10;
  localparam logic [3:0] C_SWI   = 4'd11;
  localparam logic [3:0] C_CPX   = 4'd12;
  localparam logic [3:0] C_CPD   = 4'd13;
  localparam logic [3:0] C_CPR   = 4'd14;
  localparam logic [3:0] C_UNDEF = 4'd15;

  logic       fn, fz, fc, fv;
  logic [3:0] cc;
  logic [7:0] hi, lo;
  logic       cond_ok;
  logic [3:0] cls;

  assign {fn, fz, fc, fv} = in_flags;
  assign cc = in_word[31:28];
  assign hi = in_word[27:20];
  assign lo = in_word[11:4];

  always_comb begin
    case (cc)
      4'h0: cond_ok = fz;
      4'h1: cond_ok = !fz;
      4'h2: cond_ok = fc;
      4'h3: cond_ok = !fc;
      4'h4: cond_ok = fn;
      4'h5: cond_ok = !fn;
      4'h6: cond_ok = fv;
      4'h7: cond_ok = !fv;
      4'h8: cond_ok = fc && !fz;
      4'h9: cond_ok = !fc || fz;
      4'hA: cond_ok = fn == fv;
      4'hB: cond_ok = fn != fv;
      4'hC: cond_ok = (fn == fv) && !fz;
      4'hD: cond_ok = fz || (fn != fv);
      4'hE: cond_ok = 1'b1;
      default: cond_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (hi[7:5] == 3'b011 && in_word[4])                           cls = C_UNDEF;
    else if (hi[7:6] == 2'b01)                                     cls = C_SDT;
    else if (hi[7:2] == 6'd0 && lo[3:0] == 4'b1001)                cls = C_MUL;
    else if (hi[7:3] == 5'b00001 && lo[3:0] == 4'b1001)            cls = C_MULL;
    else if (hi[7:3] == 5'b00010 && hi[1:0] == 2'b00 && lo == 8'h09) cls = C_SWAP;
    else if (hi[7:5] == 3'b000 && in_word[7] && in_word[4])        cls = C_HALF;
    else if (hi[7:5] == 3'b100)                                    cls = C_BDT;
    else if (hi[7:5] == 3'b101)                                    cls = C_BR;
    else if (hi[7:5] == 3'b110)                                    cls = C_CPX;
    else if (hi[7:4] == 4'b1111)                                   cls = C_SWI;
    else if (hi[7:4] == 4'b1110)                                   cls = in_word[4] ? C_CPR : C_CPD;
    else if (hi == 8'h12 && in_word[19:8] == 12'hFFF && in_word[7:4] == 4'b0001) cls = C_BX;
    else if (hi[7:3] == 5'b00010 && hi[1:0] == 2'b00 && lo == 8'h00) cls = C_MRS;
    else if (hi[7:6] == 2'b00 && hi[4:3] == 2'b10 && hi[1:0] == 2'b10) cls = C_MSR;
    else                                                           cls = C_DP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_exec  <= 1'b0;
      out_class <= C_DP;
      out_link  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_exec  <= cond_ok;
        out_class <= cls;
        out_link  <= (cls == C_BR) && in_word[24];
      end
    end
  end

endmodule

module insn_gate_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_word,
  input logic        out_valid,
  input logic        out_exec,
  input logic [3:0]  out_class,
  input logic        out_link
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R5
  always_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[31:28] == 4'hE) |=> out_exec);

  // R5
  never_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[31:28] == 4'hF) |=> !out_exec);

  // R9
  branch_xchg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_word[27:4] == 24'h12FFF1) |=> (out_class == 4'd8));

  // R10
  link_only_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_link |-> (out_class == 4'd7));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_class) && $stable(out_exec) && $stable(out_link)));

endmodule

bind insn_gate_decode insn_gate_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
  .out_valid(out_valid), .out_exec(out_exec), .out_class(out_class), .out_link(out_link)
);

// File: tb/insn_gate_decode_bench.sv
module insn_gate_decode_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = 32'd0;
  logic [3:0]  in_flags = 4'd0;
  logic        out_valid, out_exec, out_link;
  logic [3:0]  out_class;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic       e_valid = 1'b0, e_exec = 1'b0, e_link = 1'b0;
  logic [3:0] e_class = 4'd0;
  string      e_tag_cls = "R1", e_tag_exec = "R1";

  always #4 clk = ~clk;

  insn_gate_decode u_insn_gate_decode (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word), .in_flags(in_flags),
    .out_valid(out_valid), .out_exec(out_exec), .out_class(out_class), .out_link(out_link)
  );

  logic [31:0] pmask [16];
  logic [31:0] pval  [16];
  int          pcls  [16];

  initial begin
    pmask[0]  = 32'h0E000010; pval[0]  = 32'h06000010; pcls[0]  = 15;
    pmask[1]  = 32'h0C000000; pval[1]  = 32'h04000000; pcls[1]  = 5;
    pmask[2]  = 32'h0FC000F0; pval[2]  = 32'h00000090; pcls[2]  = 1;
    pmask[3]  = 32'h0F8000F0; pval[3]  = 32'h00800090; pcls[3]  = 2;
    pmask[4]  = 32'h0FB00FF0; pval[4]  = 32'h01000090; pcls[4]  = 3;
    pmask[5]  = 32'h0E000090; pval[5]  = 32'h00000090; pcls[5]  = 4;
    pmask[6]  = 32'h0E000000; pval[6]  = 32'h08000000; pcls[6]  = 6;
    pmask[7]  = 32'h0E000000; pval[7]  = 32'h0A000000; pcls[7]  = 7;
    pmask[8]  = 32'h0E000000; pval[8]  = 32'h0C000000; pcls[8]  = 12;
    pmask[9]  = 32'h0F000000; pval[9]  = 32'h0F000000; pcls[9]  = 11;
    pmask[10] = 32'h0F000010; pval[10] = 32'h0E000010; pcls[10] = 14;
    pmask[11] = 32'h0F000010; pval[11] = 32'h0E000000; pcls[11] = 13;
    pmask[12] = 32'h0FFFFFF0; pval[12] = 32'h012FFF10; pcls[12] = 8;
    pmask[13] = 32'h0FB00FF0; pval[13] = 32'h01000000; pcls[13] = 9;
    pmask[14] = 32'h0DB00000; pval[14] = 32'h01200000; pcls[14] = 10;
    pmask[15] = 32'h0C000000; pval[15] = 32'h00000000; pcls[15] = 0;
  end

  function automatic int ref_class(logic [31:0] w);
    for (int i = 0; i < 16; i++)
      if ((w & pmask[i]) == pval[i]) return pcls[i];
    return -1;
  endfunction

  function automatic bit ref_exec(logic [31:0] w, logic [3:0] f);
    int code = int'(w[31:28]);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    bit base;
    if (code == 14) return 1'b1;
    if (code == 15) return 1'b0;
    case (code / 2)
      0: base = z;
      1: base = c;
      2: base = n;
      3: base = v;
      4: base = c & ~z;
      5: base = (n == v);
      default: base = (n == v) & ~z;
    endcase
    return (code % 2 == 1) ? ~base : base;
  endfunction

  function automatic string class_tag(int k);
    case (k)
      0: return "R12";
      1, 2, 3: return "R7";
      4: return "R8";
      5, 15: return "R6";
      8: return "R9";
      9, 10: return "R11";
      default: return "R10";
    endcase
  endfunction

  function automatic string exec_tag(logic [3:0] code);
    if (code < 8) return "R3";
    if (code < 14) return "R4";
    return "R5";
  endfunction

  task automatic compare();
    checks++;
    if (out_valid !== e_valid) begin
      errors++;
      $display("FAIL R2 out_valid actual %0b expected %0b", out_valid, e_valid);
    end
    checks++;
    if (out_class !== e_class) begin
      errors++;
      $display("FAIL %s out_class actual %0d expected %0d", e_tag_cls, out_class, e_class);
    end
    checks++;
    if (out_exec !== e_exec) begin
      errors++;
      $display("FAIL %s out_exec actual %0b expected %0b", e_tag_exec, out_exec, e_exec);
    end
    checks++;
    if (out_link !== e_link) begin
      errors++;
      $display("FAIL %s out_link actual %0b expected %0b", (e_tag_cls == "R1") ? "R1" : "R10", out_link, e_link);
    end
  endtask

  task automatic step(bit v, logic [31:0] w, logic [3:0] f);
    int k;
    @(negedge clk);
    compare();
    in_valid = v;
    in_word  = w;
    in_flags = f;
    e_valid  = v;
    if (v) begin
      k = ref_class(w);
      e_class    = 4'(k);
      e_exec     = ref_exec(w, f);
      e_link     = (k == 7) && w[24];
      e_tag_cls  = class_tag(k);
      e_tag_exec = exec_tag(w[31:28]);
    end else if (e_tag_cls != "R1") begin
      e_tag_cls  = "R13";
      e_tag_exec = "R13";
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    checks++;
    if (out_valid !== 1'b0 || out_exec !== 1'b0 || out_class !== 4'd0 || out_link !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs actual %0b%0b%0d%0b expected 0000", out_valid, out_exec, out_class, out_link);
    end
    rst_n = 1'b1;
    step(0, 32'hFFFFFFFF, 4'hF);
    step(0, 32'h0, 4'h0);

    // R3 R4 R5: every condition code with every flag combination
    for (int cc = 0; cc < 16; cc++)
      for (int fl = 0; fl < 16; fl++)
        step(1, {4'(cc), 28'h0810002}, 4'(fl));

    // R6 .. R12: directed class patterns and priority boundaries
    step(1, 32'hE6000010, 4'h0);  // R6 undefined
    step(1, 32'hE6000000, 4'h0);  // R6 single transfer
    step(1, 32'hE5900000, 4'h0);
    step(1, 32'hE0000091, 4'h0);  // R7 multiply
    step(1, 32'hE0300091, 4'h0);
    step(1, 32'hE0800091, 4'h0);  // R7 long multiply
    step(1, 32'hE0F00091, 4'h0);
    step(1, 32'hE1000091, 4'h0);  // R7 swap
    step(1, 32'hE1400091, 4'h0);
    step(1, 32'hE1000F91, 4'h0);  // R8 swap-like with bits 11:8 set
    step(1, 32'hE1D000B0, 4'h0);  // R8 halfword
    step(1, 32'hE00000F0, 4'h0);
    step(1, 32'hE12FFF11, 4'h0);  // R9 branch-exchange
    step(1, 32'h012FFF1E, 4'h4);
    step(1, 32'hE12FFE11, 4'h0);  // R9 near miss becomes status write
    step(1, 32'hE8BD0003, 4'h0);  // R10 block
    step(1, 32'hEA000000, 4'h0);  // R10 branch
    step(1, 32'hEB000000, 4'h0);  // R10 branch with link
    step(1, 32'hEC000000, 4'h0);  // R10 coprocessor transfer
    step(1, 32'hEE000000, 4'h0);  // R10 coprocessor data
    step(1, 32'hEE000010, 4'h0);  // R10 coprocessor register
    step(1, 32'hEF000000, 4'h0);  // R10 software interrupt
    step(1, 32'hE10F0000, 4'h0);  // R11 status read
    step(1, 32'hE14F0000, 4'h0);
    step(1, 32'hE10F0010, 4'h0);  // R12 near miss of status read
    step(1, 32'hE129F001, 4'h0);  // R11 status write
    step(1, 32'hE328F00F, 4'h0);
    step(1, 32'hE0810002, 4'h0);  // R12 data processing
    step(1, 32'hE3A00001, 4'h0);

    // R13: link and class hold across idle cycles
    step(1, 32'hEB000010, 4'h0);
    step(0, 32'hE0000000, 4'h0);
    step(0, 32'hF0000000, 4'h0);
    step(1, 32'h5A000000, 4'h0);
    step(0, 32'hEF000000, 4'hF);

    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, $urandom, 4'($urandom));
    step(0, 32'h0, 4'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule